// File: doc/BRIEF.md
# Interrupt-Pulse Boot Image Sender

This block loads a boot image into a small 8-bit processor whose only built-in code is a tiny loader. The sender does not use a data line. It encodes each bit by choosing which interrupt line to pulse. A low pulse on the edge-triggered non-maskable interrupt delivers a 0. A low pulse on the maskable interrupt request delivers a 1. The loader rotates every bit into the bottom of its accumulator, so each byte leaves most significant bit first. Eight events make one byte, and the loader stores the bytes at consecutive addresses starting from zero.

Bytes arrive on a valid/ready stream that carries a last-byte flag. Each bit event is followed by a programmable quiet gap that covers the loader's service time. After the final bit of a byte marked last, and after its gap, the block pulses the processor's set-overflow input low. This releases the waiting loader, which then jumps to address zero. The three length inputs are sampled when the phase they time begins, so they should be held steady while a frame is in flight.

Top module: `irq_boot_sender`

## Requirements
- R1: While the reset is active and in the first cycle after it, `nmi_n_o`, `irq_n_o` and `so_n_o` are high, `busy_o` is low and `s_ready_o` is high.
- R2: A 0 bit drives `nmi_n_o` low for max(`nmi_len_i`,1) cycles, then high again. Every 0 bit therefore starts with its own falling edge.
- R3: A 1 bit drives `irq_n_o` low for max(`irq_len_i`,1) cycles, then releases it.
- R4: An accepted byte produces exactly eight pulse events, bit 7 first and bit 0 last. Bytes are sent in the order they were accepted.
- R5: After every pulse, both interrupt lines stay high for exactly max(`gap_len_i`,1) cycles before the next pulse of the same byte. Between two bytes they stay high for more than that.
- R6: The two interrupt lines are never low in the same cycle.
- R7: `s_ready_o` is high only when no pulse, gap or set-overflow phase is running. It is low whenever any output pulse is low.
- R8: `so_n_o` goes low for exactly SO_LEN cycles only after all bits of a byte accepted with `s_last_i`=1 have been sent and the final gap has completed. A byte without the flag never leads to a set-overflow pulse.
- R9: `busy_o` rises in the cycle after the first byte of a frame is accepted. It stays high between bytes and through the set-overflow pulse, and falls in the same cycle that `so_n_o` returns high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| s_data_i | input | DATA_W | Byte to send |
| s_last_i | input | 1 | Marks the final byte of the image |
| s_valid_i | input | 1 | Stream valid |
| s_ready_o | output | 1 | Stream ready, high between bytes |
| nmi_len_i | input | CNT_W | Low time of a 0-bit pulse, in cycles (0 is treated as 1) |
| irq_len_i | input | CNT_W | Low time of a 1-bit pulse, in cycles (0 is treated as 1) |
| gap_len_i | input | CNT_W | Quiet cycles after each bit (0 is treated as 1) |
| nmi_n_o | output | 1 | Non-maskable interrupt, active low |
| irq_n_o | output | 1 | Interrupt request, active low |
| so_n_o | output | 1 | Set-overflow pulse, active low |
| busy_o | output | 1 | High while a frame is in progress |

## Verification
The bench builds the block with DATA_W=8, CNT_W=8 and SO_LEN=3. Each frame uses pulse and gap lengths between 0 and 5, so the zero-means-one clamp and single-cycle phases are reached alongside multi-cycle ones. With these short lengths, dozens of random multi-byte frames fit in the run. The directed frames add all-zero and all-one bytes, a stalled stream between bytes, and a long pause after a byte without the last flag.

// File: rtl/boot_pkg.sv
package boot_pkg;
  typedef enum logic [1:0] {
    ST_IDLE,
    ST_PULSE,
    ST_GAP,
    ST_SETV
  } seq_state_e;
endpackage

// File: rtl/boot_phase_timer.sv
module boot_phase_timer #(
  parameter int CNT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [CNT_W-1:0] len_i,
  output logic             done_o
);
  logic [CNT_W-1:0] cnt_q;

  // phase lasts max(len,1) cycles; done flags its last cycle
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)               cnt_q <= '0;
    else if (load_i)           cnt_q <= (len_i == '0) ? CNT_W'(1) : len_i;
    else if (cnt_q > CNT_W'(1)) cnt_q <= cnt_q - CNT_W'(1);
  end

  assign done_o = (cnt_q <= CNT_W'(1));
endmodule

// File: rtl/boot_bit_shifter.sv
module boot_bit_shifter #(
  parameter int DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic              shift_i,
  output logic              msb_o,
  output logic              next_o,
  output logic              last_bit_o
);
  localparam int IDX_W = $clog2(DATA_W);

  logic [DATA_W-1:0] sh_q;
  logic [IDX_W-1:0]  idx_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sh_q  <= '0;
      idx_q <= '0;
    end else if (load_i) begin
      sh_q  <= data_i;
      idx_q <= '0;
    end else if (shift_i) begin
      sh_q  <= {sh_q[DATA_W-2:0], 1'b0};
      idx_q <= idx_q + IDX_W'(1);
    end
  end

  assign msb_o      = sh_q[DATA_W-1];
  assign next_o     = sh_q[DATA_W-2];
  assign last_bit_o = (idx_q == IDX_W'(DATA_W-1));
endmodule

// File: rtl/irq_boot_sender.sv
module irq_boot_sender
  import boot_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int CNT_W  = 8,
  parameter int SO_LEN = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [DATA_W-1:0] s_data_i,
  input  logic              s_last_i,
  input  logic              s_valid_i,
  output logic              s_ready_o,
  input  logic [CNT_W-1:0]  nmi_len_i,
  input  logic [CNT_W-1:0]  irq_len_i,
  input  logic [CNT_W-1:0]  gap_len_i,
  output logic              nmi_n_o,
  output logic              irq_n_o,
  output logic              so_n_o,
  output logic              busy_o
);
  localparam logic [CNT_W-1:0] SO_CNT = CNT_W'(SO_LEN);

  seq_state_e       state_q, state_d;
  logic             frame_q, frame_d;
  logic             last_q, last_d;
  logic             tmr_load, tmr_done;
  logic [CNT_W-1:0] tmr_len;
  logic             sh_load, sh_shift;
  logic             cur_bit, next_bit, last_bit;

  boot_phase_timer #(.CNT_W(CNT_W)) u_tmr (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (tmr_load),
    .len_i  (tmr_len),
    .done_o (tmr_done)
  );

  boot_bit_shifter #(.DATA_W(DATA_W)) u_shift (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (sh_load),
    .data_i     (s_data_i),
    .shift_i    (sh_shift),
    .msb_o      (cur_bit),
    .next_o     (next_bit),
    .last_bit_o (last_bit)
  );

  always_comb begin
    state_d  = state_q;
    frame_d  = frame_q;
    last_d   = last_q;
    tmr_load = 1'b0;
    tmr_len  = '0;
    sh_load  = 1'b0;
    sh_shift = 1'b0;
    unique case (state_q)
      ST_IDLE: if (s_valid_i) begin
        sh_load  = 1'b1;
        tmr_load = 1'b1;
        tmr_len  = s_data_i[DATA_W-1] ? irq_len_i : nmi_len_i;
        last_d   = s_last_i;
        frame_d  = 1'b1;
        state_d  = ST_PULSE;
      end
      ST_PULSE: if (tmr_done) begin
        tmr_load = 1'b1;
        tmr_len  = gap_len_i;
        state_d  = ST_GAP;
      end
      ST_GAP: if (tmr_done) begin
        if (!last_bit) begin
          sh_shift = 1'b1;
          tmr_load = 1'b1;
          tmr_len  = next_bit ? irq_len_i : nmi_len_i;
          state_d  = ST_PULSE;
        end else if (last_q) begin
          tmr_load = 1'b1;
          tmr_len  = SO_CNT;
          state_d  = ST_SETV;
        end else begin
          state_d  = ST_IDLE;
        end
      end
      ST_SETV: if (tmr_done) begin
        frame_d = 1'b0;
        state_d = ST_IDLE;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      frame_q <= 1'b0;
      last_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      frame_q <= frame_d;
      last_q  <= last_d;
    end
  end

  assign s_ready_o = (state_q == ST_IDLE);
  assign nmi_n_o   = !((state_q == ST_PULSE) && !cur_bit);
  assign irq_n_o   = !((state_q == ST_PULSE) && cur_bit);
  assign so_n_o    = (state_q != ST_SETV);
  assign busy_o    = frame_q;
endmodule

// File: rtl/boot_sender_checker.sv
module boot_sender_checker (
  input logic clk_i,
  input logic rst_ni,
  input logic s_ready_o,
  input logic nmi_n_o,
  input logic irq_n_o,
  input logic so_n_o,
  input logic busy_o
);
  assert_one_line_low_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(!nmi_n_o && !irq_n_o));

  assert_ready_quiet_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!nmi_n_o || !irq_n_o || !so_n_o) |-> !s_ready_o);

  assert_pulse_in_frame_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!nmi_n_o || !irq_n_o) |-> busy_o);

  assert_gap_follows_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($rose(nmi_n_o) || $rose(irq_n_o)) |-> (nmi_n_o && irq_n_o && so_n_o));

  assert_so_after_quiet_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(so_n_o) |-> ($past(nmi_n_o) && $past(irq_n_o)));

  assert_busy_in_so_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !so_n_o |-> busy_o);

  assert_busy_drop_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(so_n_o) |-> !busy_o);
endmodule

bind irq_boot_sender boot_sender_checker u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .s_ready_o (s_ready_o),
  .nmi_n_o   (nmi_n_o),
  .irq_n_o   (irq_n_o),
  .so_n_o    (so_n_o),
  .busy_o    (busy_o)
);

// File: tb/sim_irq_boot_sender.sv
`timescale 1ns/1ps
module sim_irq_boot_sender;
  localparam int DATA_W = 8;
  localparam int CNT_W  = 8;
  localparam int SO_LEN = 3;

  logic              clk_i = 1'b0;
  logic              rst_ni = 1'b0;
  logic [DATA_W-1:0] s_data_i = '0;
  logic              s_last_i = 1'b0;
  logic              s_valid_i = 1'b0;
  logic              s_ready_o;
  logic [CNT_W-1:0]  nmi_len_i = 8'd1;
  logic [CNT_W-1:0]  irq_len_i = 8'd1;
  logic [CNT_W-1:0]  gap_len_i = 8'd1;
  logic              nmi_n_o, irq_n_o, so_n_o, busy_o;

  always #2 clk_i = ~clk_i;

  irq_boot_sender #(.DATA_W(DATA_W), .CNT_W(CNT_W), .SO_LEN(SO_LEN)) u0 (
    .clk_i(clk_i), .rst_ni(rst_ni), .s_data_i(s_data_i), .s_last_i(s_last_i),
    .s_valid_i(s_valid_i), .s_ready_o(s_ready_o), .nmi_len_i(nmi_len_i),
    .irq_len_i(irq_len_i), .gap_len_i(gap_len_i), .nmi_n_o(nmi_n_o),
    .irq_n_o(irq_n_o), .so_n_o(so_n_o), .busy_o(busy_o)
  );

  int checks = 0;
  int failures = 0;
  bit exp_q[$];
  int frame_bits_exp = 0;
  int bits_seen = 0;
  int so_falls = 0;
  int low_cnt = 0, hi_cnt = 0, so_cnt = 0;
  logic p_nmi = 1'b1, p_irq = 1'b1, p_so = 1'b1;
  logic [7:0] img [8];

  function automatic int eff(int v);
    return (v == 0) ? 1 : v;
  endfunction

  task automatic chk(bit ok, string tag, int act, int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d t=%0t", tag, act, exp, $time);
    end
  endtask

  // output monitor, sampled on the falling edge
  always @(negedge clk_i) begin
    if (rst_ni) begin
      if (!nmi_n_o && !irq_n_o) chk(0, "R6 both lines low", 1, 0);
      if (!nmi_n_o || !irq_n_o || !so_n_o) chk(!s_ready_o, "R7 ready during phase", s_ready_o, 0);
      if ((p_nmi && !nmi_n_o) || (p_irq && !irq_n_o)) begin
        bit b, e;
        b = !irq_n_o;
        if (exp_q.size() == 0) chk(0, "R4 unexpected pulse", b, -1);
        else begin
          e = exp_q.pop_front();
          chk(b == e, "R4 bit order", b, e);
        end
        if (bits_seen % 8 != 0) chk(hi_cnt == eff(gap_len_i), "R5 gap in byte", hi_cnt, eff(gap_len_i));
        else if (bits_seen != 0) chk(hi_cnt > eff(gap_len_i), "R5 gap across bytes", hi_cnt, eff(gap_len_i) + 1);
        chk(busy_o, "R9 busy during pulse", busy_o, 1);
        bits_seen++;
        low_cnt = 1;
      end else if (!nmi_n_o || !irq_n_o) begin
        low_cnt++;
      end
      if (!p_nmi && nmi_n_o) begin
        chk(low_cnt == eff(nmi_len_i), "R2 nmi low time", low_cnt, eff(nmi_len_i));
        hi_cnt = 1;
      end else if (!p_irq && irq_n_o) begin
        chk(low_cnt == eff(irq_len_i), "R3 irq low time", low_cnt, eff(irq_len_i));
        hi_cnt = 1;
      end else if (nmi_n_o && irq_n_o && so_n_o) begin
        hi_cnt++;
      end
      if (p_so && !so_n_o) begin
        chk(bits_seen == frame_bits_exp, "R8 so after all bits", bits_seen, frame_bits_exp);
        chk(hi_cnt == eff(gap_len_i), "R8 so after final gap", hi_cnt, eff(gap_len_i));
        chk(busy_o, "R9 busy at so", busy_o, 1);
        so_falls++;
        so_cnt = 1;
      end else if (!so_n_o) begin
        so_cnt++;
      end
      if (!p_so && so_n_o) begin
        chk(so_cnt == SO_LEN, "R8 so width", so_cnt, SO_LEN);
        chk(!busy_o, "R9 busy falls with so", busy_o, 0);
        bits_seen = 0;
      end
    end
    p_nmi = nmi_n_o;
    p_irq = irq_n_o;
    p_so  = so_n_o;
  end

  task automatic send_byte(logic [7:0] d, bit last, bit first);
    for (int i = 7; i >= 0; i--) exp_q.push_back(d[i]);
    s_data_i  = d;
    s_last_i  = last;
    s_valid_i = 1'b1;
    forever begin
      if (s_ready_o) begin
        @(posedge clk_i);
        break;
      end
      @(negedge clk_i);
    end
    @(negedge clk_i);
    s_valid_i = 1'b0;
    if (first) chk(busy_o, "R9 busy after first accept", busy_o, 1);
  endtask

  task automatic run_frame(int n, int nl, int il, int gl, bit pause, bit stall);
    int f0;
    @(negedge clk_i);
    nmi_len_i = CNT_W'(nl);
    irq_len_i = CNT_W'(il);
    gap_len_i = CNT_W'(gl);
    frame_bits_exp = 8 * n;
    f0 = so_falls;
    for (int i = 0; i < n; i++) begin
      if (stall) repeat ($urandom_range(0, 3)) @(negedge clk_i);
      send_byte(img[i], i == n - 1, i == 0);
      if (pause && i == 0 && n > 1) begin
        repeat (8 * (eff(nl) + eff(il) + eff(gl)) + 20) @(negedge clk_i);
        chk(so_falls == f0, "R8 no so without last", so_falls, f0);
        chk(busy_o, "R9 busy between bytes", busy_o, 1);
        chk(s_ready_o, "R7 ready between bytes", s_ready_o, 1);
      end
    end
    while (!(so_falls == f0 + 1 && !busy_o)) @(negedge clk_i);
    chk(exp_q.size() == 0, "R4 all bits sent", exp_q.size(), 0);
    chk(s_ready_o && nmi_n_o && irq_n_o && so_n_o, "R7 idle after frame", s_ready_o, 1);
  endtask

  initial begin
    repeat (150000) @(posedge clk_i);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk_i);
    chk(nmi_n_o && irq_n_o && so_n_o, "R1 lines idle in reset", {nmi_n_o, irq_n_o, so_n_o}, 7);
    chk(!busy_o && s_ready_o, "R1 busy/ready in reset", {busy_o, s_ready_o}, 1);
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk(nmi_n_o && irq_n_o && so_n_o, "R1 lines idle after reset", {nmi_n_o, irq_n_o, so_n_o}, 7);
    chk(!busy_o && s_ready_o, "R1 busy/ready after reset", {busy_o, s_ready_o}, 1);

    img[0] = 8'h00;                         run_frame(1, 0, 2, 0, 0, 0); // R2 all zeros
    img[0] = 8'hFF;                         run_frame(1, 1, 0, 3, 0, 0); // R3 all ones
    img[0] = 8'hA5; img[1] = 8'h5A; img[2] = 8'h3C;
    run_frame(3, 2, 3, 1, 1, 0);                                         // R8 paused, no last
    img[0] = 8'h80; img[1] = 8'h01;         run_frame(2, 5, 4, 5, 0, 1); // R4 bit order, stalls
    for (int f = 0; f < 24; f++) begin
      int n;
      n = $urandom_range(1, 5);
      for (int i = 0; i < n; i++) img[i] = 8'($urandom);
      run_frame(n, $urandom_range(0, 4), $urandom_range(0, 4), $urandom_range(0, 4),
                ($urandom_range(0, 3) == 0), $urandom_range(0, 1) == 1);
    end
    repeat (5) @(negedge clk_i);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule